// File: doc/BRIEF.md
# Coupled Flow/Volume Euler Step Element

This block is a fixed-function processing element that advances one coupled pair of state variables, a volume-like quantity V and a flow-like quantity F, by a single forward-Euler timestep each time it is told to start. The rates are hard-wired: dV/dt is the difference between two neighbour flows (inflow minus outflow), and dF/dt is the difference between two neighbour pressures (upstream minus downstream) less a damping term formed from F and two per-element constants. There is no instruction fetch. A small controller walks a fixed schedule that shares one subtractor, one multiplier and one adder.

Neighbour values arrive on several parallel input ports. One port is picked by a select field and written into a small local RAM at a given address. The initial V and F go into two reserved RAM words through the same path. The two constants and the timestep are held in a constant ROM set by parameters. After a one-cycle start pulse the element computes both rates from the pre-step state, writes the new V and F back into the RAM, shows them on its outputs and pulses done. A host network can chain steps by pulsing start again, refreshing the neighbour words between steps as needed.

Top module: `ode_euler_pe`

## Requirements
- R1: After reset, busy and done are 0, and v_out and f_out read 0.
- R2: When idle, a write with in_we=1 stores the value on input port in_sel (bits in_sel*32 upward of in_data) at in_addr. The address map is 0=inflow, 1=outflow, 2=upstream pressure, 3=downstream pressure, 4=V, 5=F. A write to 4 or 5 also appears on v_out or f_out on the next cycle.
- R3: One step sets V to V + dt*(inflow - outflow).
- R4: One step sets F to F + dt*(up - down - (F*CR)*CL). The damping term uses the pre-step F, and CR, CL and dt come from parameters.
- R5: All values are signed Q16.16. Each product is shifted right by 16 with rounding toward minus infinity. Every subtraction, product and sum saturates to the range 0x80000000..0x7FFFFFFF.
- R6: done is high for exactly one cycle, 12 clock cycles after the edge that accepts start. busy is high from the following cycle until done falls. v_out and f_out hold the new state while done is high.
- R7: A start pulse while busy is ignored. It produces no second done and does not change the result.
- R8: Writes while busy are ignored. They change neither the current step nor the stored values used by later steps.
- R9: Steps can be chained. A later step starts from the state that the previous step wrote back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sel | input | 2 | Selects which input port feeds a write |
| in_addr | input | 3 | Local RAM word to write |
| in_we | input | 1 | Write strobe (honoured only when idle) |
| in_data | input | 128 | Four 32-bit Q16.16 input ports, packed |
| start | input | 1 | One-cycle pulse that begins a step |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle pulse: new state is on the outputs |
| v_out | output | 32 | Current V, Q16.16 |
| f_out | output | 32 | Current F, Q16.16 |

## Verification
The bench goes after the arithmetic edges first. A one-LSB negative rate times a small dt checks floor rounding; a design that truncated toward zero would leave V unchanged. Extreme inflow and outflow values force a saturating difference and a saturating sum; a design that wrapped would flip V to a large negative value. It then pulses start and writes the inflow and V words in the middle of a step. A design that honoured either would give a second done, corrupted outputs, or a following step built on the injected value. Chained steps without reloading show whether the write-back lands in the words the next step reads. An F-dependent damping term shows whether the damping uses the pre-step F or a half-updated one.

// File: rtl/ode_pkg.sv
package ode_pkg;

  localparam int Q_W    = 32;
  localparam int Q_FRAC = 16;

  typedef logic signed [Q_W-1:0] q_t;

  localparam longint Q_MAXL = 64'sd2147483647;
  localparam longint Q_MINL = -64'sd2147483648;

  // reserved local RAM words
  localparam int ADR_FIN  = 0;
  localparam int ADR_FOUT = 1;
  localparam int ADR_PUP  = 2;
  localparam int ADR_PDN  = 3;
  localparam int ADR_V    = 4;
  localparam int ADR_F    = 5;

  // constant ROM slots
  localparam logic [1:0] ROM_CR = 2'd0;
  localparam logic [1:0] ROM_CL = 2'd1;
  localparam logic [1:0] ROM_DT = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LD_FIN,
    ST_SUB_DV,
    ST_LD_PUP,
    ST_SUB_PP,
    ST_MUL_FR,
    ST_MUL_CL,
    ST_SUB_DF,
    ST_MUL_DV,
    ST_ADD_V,
    ST_MUL_DF,
    ST_ADD_F,
    ST_FIN
  } pe_state_e;

  function automatic q_t q_clip(input longint x);
    longint y;
    if (x > Q_MAXL)      y = Q_MAXL;
    else if (x < Q_MINL) y = Q_MINL;
    else                 y = x;
    return q_t'(y[Q_W-1:0]);
  endfunction

  function automatic q_t q_add(input q_t a, input q_t b);
    return q_clip(longint'(a) + longint'(b));
  endfunction

  function automatic q_t q_sub(input q_t a, input q_t b);
    return q_clip(longint'(a) - longint'(b));
  endfunction

  // arithmetic shift floors the product before clipping
  function automatic q_t q_mul(input q_t a, input q_t b);
    longint p;
    p = longint'(a) * longint'(b);
    return q_clip(p >>> Q_FRAC);
  endfunction

endpackage

// File: rtl/ode_local_ram.sv
module ode_local_ram import ode_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  q_t            wdata,
  input  logic [AW-1:0] raddr,
  output q_t            rdata
);

  q_t words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    q_t word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      word_q <= '0;
      else if (we && waddr == AW'(g))  word_q <= wdata;
    end
    assign words[g] = word_q;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/ode_const_rom.sv
module ode_const_rom import ode_pkg::*; #(
  parameter int CR_Q = 32768,
  parameter int CL_Q = 98304,
  parameter int DT_Q = 655
) (
  input  logic [1:0] idx,
  output q_t         data
);

  always_comb begin
    case (idx)
      ROM_CR:  data = q_t'(CR_Q);
      ROM_CL:  data = q_t'(CL_Q);
      ROM_DT:  data = q_t'(DT_Q);
      default: data = '0;
    endcase
  end

endmodule

// File: rtl/ode_ctrl.sv
module ode_ctrl import ode_pkg::*; #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output pe_state_e     st,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rom_idx,
  output logic          core_we,
  output logic [AW-1:0] core_addr,
  output logic          step_start,
  output logic          wb_v,
  output logic          wb_f,
  output logic          busy,
  output logic          done
);

  pe_state_e nxt;

  always_comb begin
    case (st)
      ST_IDLE: nxt = start ? ST_LD_FIN : ST_IDLE;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = pe_state_e'(4'(st) + 4'd1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    case (st)
      ST_LD_FIN: rd_addr = AW'(ADR_FIN);
      ST_SUB_DV: rd_addr = AW'(ADR_FOUT);
      ST_LD_PUP: rd_addr = AW'(ADR_PUP);
      ST_SUB_PP: rd_addr = AW'(ADR_PDN);
      ST_MUL_FR: rd_addr = AW'(ADR_F);
      ST_MUL_DV: rd_addr = AW'(ADR_V);
      default:   rd_addr = AW'(ADR_FIN);
    endcase
  end

  always_comb begin
    case (st)
      ST_MUL_FR: rom_idx = ROM_CR;
      ST_MUL_CL: rom_idx = ROM_CL;
      default:   rom_idx = ROM_DT;
    endcase
  end

  assign wb_v       = (st == ST_ADD_V);
  assign wb_f       = (st == ST_ADD_F);
  assign core_we    = wb_v | wb_f;
  assign core_addr  = wb_v ? AW'(ADR_V) : AW'(ADR_F);
  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_FIN);
  assign step_start = (st == ST_IDLE) && start;

endmodule

// File: rtl/ode_datapath.sv
module ode_datapath import ode_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  pe_state_e st,
  input  q_t        rdata,
  input  q_t        cdata,
  output q_t        sum
);

  q_t acc_a, rate_v, p_diff, rate_f, prod, f_old, v_old;
  q_t sub_a, sub_b, sub_y;
  q_t mul_a, mul_b, mul_y;
  q_t add_a;

  // one shared subtractor
  always_comb begin
    case (st)
      ST_SUB_DF: begin sub_a = p_diff; sub_b = prod;  end
      default:   begin sub_a = acc_a;  sub_b = rdata; end
    endcase
    sub_y = q_sub(sub_a, sub_b);
  end

  // one shared multiplier
  always_comb begin
    case (st)
      ST_MUL_FR: begin mul_a = rdata; mul_b = cdata; end
      ST_MUL_CL: begin mul_a = prod;  mul_b = cdata; end
      ST_MUL_DV: begin mul_a = cdata; mul_b = rate_v; end
      default:   begin mul_a = cdata; mul_b = rate_f; end
    endcase
    mul_y = q_mul(mul_a, mul_b);
  end

  // Euler accumulate
  assign add_a = (st == ST_ADD_V) ? v_old : f_old;
  assign sum   = q_add(add_a, prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a  <= '0;
      rate_v <= '0;
      p_diff <= '0;
      rate_f <= '0;
      prod   <= '0;
      f_old  <= '0;
      v_old  <= '0;
    end else begin
      case (st)
        ST_LD_FIN: acc_a  <= rdata;
        ST_SUB_DV: rate_v <= sub_y;
        ST_LD_PUP: acc_a  <= rdata;
        ST_SUB_PP: p_diff <= sub_y;
        ST_MUL_FR: begin f_old <= rdata; prod <= mul_y; end
        ST_MUL_CL: prod   <= mul_y;
        ST_SUB_DF: rate_f <= sub_y;
        ST_MUL_DV: begin v_old <= rdata; prod <= mul_y; end
        ST_MUL_DF: prod   <= mul_y;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ode_euler_pe.sv
module ode_euler_pe import ode_pkg::*; #(
  parameter int NPORT     = 4,
  parameter int RAM_DEPTH = 8,
  parameter int CR_Q      = 32768,
  parameter int CL_Q      = 98304,
  parameter int DT_Q      = 655,
  localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int AW    = $clog2(RAM_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     in_sel,
  input  logic [AW-1:0]        in_addr,
  input  logic                 in_we,
  input  logic [NPORT*Q_W-1:0] in_data,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [Q_W-1:0]       v_out,
  output logic [Q_W-1:0]       f_out
);

  q_t port_w [NPORT];
  q_t sel_data;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_w[p] = q_t'(in_data[p*Q_W +: Q_W]);
  end
  assign sel_data = port_w[in_sel];

  pe_state_e       st;
  logic [AW-1:0]   rd_addr, core_addr, ram_waddr;
  logic [1:0]      rom_idx;
  logic            core_we, step_start, wb_v, wb_f, ext_acc, ram_we;
  q_t              ram_rdata, rom_data, sum, ram_wdata;

  ode_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .st(st),
    .rd_addr(rd_addr), .rom_idx(rom_idx), .core_we(core_we),
    .core_addr(core_addr), .step_start(step_start),
    .wb_v(wb_v), .wb_f(wb_f), .busy(busy), .done(done)
  );

  assign ext_acc   = in_we && !busy;
  assign ram_we    = core_we | ext_acc;
  assign ram_waddr = core_we ? core_addr : in_addr;
  assign ram_wdata = core_we ? sum : sel_data;

  ode_local_ram #(.DEPTH(RAM_DEPTH)) ram_i (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr),
    .wdata(ram_wdata), .raddr(rd_addr), .rdata(ram_rdata)
  );

  ode_const_rom #(.CR_Q(CR_Q), .CL_Q(CL_Q), .DT_Q(DT_Q)) rom_i (
    .idx(rom_idx), .data(rom_data)
  );

  ode_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .rdata(ram_rdata),
    .cdata(rom_data), .sum(sum)
  );

  // visible copies of the state words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= '0;
      f_out <= '0;
    end else begin
      if (wb_v || (ext_acc && in_addr == AW'(ADR_V))) v_out <= ram_wdata;
      if (wb_f || (ext_acc && in_addr == AW'(ADR_F))) f_out <= ram_wdata;
    end
  end

endmodule

// File: rtl/ode_euler_pe_chk.sv
module ode_euler_pe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] v_out,
  input logic [31:0] f_out,
  input logic        step_start,
  input logic        wb_v,
  input logic        wb_f
);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(step_start, 12));

  assert_done_after_f_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wb_f));

  assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy && !step_start));

  assert_outs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wb_v && !wb_f) |=> ($stable(v_out) && $stable(f_out)));

endmodule

bind ode_euler_pe ode_euler_pe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .v_out(v_out), .f_out(f_out), .step_start(step_start),
  .wb_v(wb_v), .wb_f(wb_f)
);

// File: tb/ode_euler_pe_tb_top.sv
module ode_euler_pe_tb_top;

  localparam int NP = 4;
  localparam int CR = 32768;
  localparam int CL = 98304;
  localparam int DT = 655;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    in_sel = '0;
  logic [2:0]    in_addr = '0;
  logic          in_we = 1'b0;
  logic [NP*32-1:0] in_data = '0;
  logic          start = 1'b0;
  logic          busy, done;
  logic [31:0]   v_out, f_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  int m_fin, m_fout, m_pup, m_pdn, m_v, m_f;

  always #5 clk = ~clk;

  ode_euler_pe #(.NPORT(NP), .RAM_DEPTH(8), .CR_Q(CR), .CL_Q(CL), .DT_Q(DT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_sel(in_sel), .in_addr(in_addr), .in_we(in_we),
    .in_data(in_data), .start(start), .busy(busy), .done(done),
    .v_out(v_out), .f_out(f_out)
  );

  function automatic int m_sat(input longint x);
    if (x > 64'sd2147483647) return 32'sh7FFFFFFF;
    if (x < -64'sd2147483648) return 32'sh80000000;
    return int'(x);
  endfunction

  function automatic int m_mul(input int a, input int b);
    longint p, q;
    p = longint'(a) * longint'(b);
    q = p / 65536;
    if (p < 0 && (p % 65536) != 0) q = q - 1;
    return m_sat(q);
  endfunction

  function automatic int m_next_v();
    int rate;
    rate = m_sat(longint'(m_fin) - longint'(m_fout));
    return m_sat(longint'(m_v) + longint'(m_mul(DT, rate)));
  endfunction

  function automatic int m_next_f();
    int drop, damp, rate;
    drop = m_sat(longint'(m_pup) - longint'(m_pdn));
    damp = m_mul(m_mul(m_f, CR), CL);
    rate = m_sat(longint'(drop) - longint'(damp));
    return m_sat(longint'(m_f) + longint'(m_mul(DT, rate)));
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int addr, input int val);
    @(negedge clk);
    for (int p = 0; p < NP; p++) in_data[p*32 +: 32] = $urandom;
    in_data[sel*32 +: 32] = val;
    in_sel = 2'(sel);
    in_addr = 3'(addr);
    in_we = 1'b1;
    @(negedge clk);
    in_we = 1'b0;
  endtask

  task automatic load_all(input int a, input int b, input int c, input int d,
                          input int v, input int f, input bit check_out);
    wr(0, 0, a); wr(1, 1, b); wr(2, 2, c); wr(3, 3, d);
    wr(1, 4, v);
    if (check_out) chk("R2", "v_out after load", int'(v_out), v);
    wr(2, 5, f);
    if (check_out) chk("R2", "f_out after load", int'(f_out), f);
    m_fin = a; m_fout = b; m_pup = c; m_pdn = d; m_v = v; m_f = f;
  endtask

  // pulse start; optionally inject a start or a write at a given cycle of the step
  task automatic do_step(input int inj_start_at, input int inj_wr_at,
                         input int wr_addr, input int wr_val, output int lat);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      in_we = 1'b0;
      lat++;
      if (done || lat > 40) break;
      if (lat == inj_start_at) start = 1'b1;
      if (lat == inj_wr_at) begin
        in_sel = 2'd0;
        in_addr = 3'(wr_addr);
        in_data = {NP{wr_val}};
        in_we = 1'b1;
      end
    end
    start = 1'b0;
    in_we = 1'b0;
  endtask

  task automatic step_and_check(input string tag);
    int lat, ev, ef;
    ev = m_next_v();
    ef = m_next_f();
    do_step(-1, -1, 0, 0, lat);
    chk("R6", {tag, " latency"}, lat, 12);
    chk("R3", {tag, " v_out"}, int'(v_out), ev);
    chk("R4", {tag, " f_out"}, int'(f_out), ef);
    m_v = ev; m_f = ef;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R6 watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, ev, ef, extra;
    void'($urandom(32'd7719));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "v_out", v_out, 0);
    chk("R1", "f_out", f_out, 0);

    // R2 load through different ports, then a directed step (R3 R4 R6)
    load_all(32'sh0003_0000, 32'sh0001_8000, 32'sh0010_0000, 32'sh0002_0000,
             32'sh0005_0000, 32'sh0004_0000, 1'b1);
    ev = m_next_v(); ef = m_next_f();
    do_step(-1, -1, 0, 0, lat);
    chk("R6", "done latency", lat, 12);
    chk("R6", "busy with done", busy, 1);
    chk("R3", "V after step", int'(v_out), ev);
    chk("R4", "F after step", int'(f_out), ef);
    m_v = ev; m_f = ef;
    @(negedge clk);
    chk("R6", "done one cycle", done, 0);
    chk("R6", "busy after done", busy, 0);

    // R9 chained steps start from written-back state
    step_and_check("R9 chain 1");
    step_and_check("R9 chain 2");

    // R5 floor rounding: rate of -1 LSB times dt must give -1 LSB
    load_all(0, 1, 0, 0, 32'sd1000, 0, 1'b0);
    step_and_check("R5 floor");
    chk("R5", "floor V", int'(v_out), 999);

    // R5 saturation of difference, product and sum
    load_all(32'sh7FFFFFFF, 32'sh80000000, 32'sh7FFFFFFF, 32'sh80000000,
             32'sh7FFF0000, 32'sh80000000, 1'b0);
    step_and_check("R5 sat");
    chk("R5", "V saturates high", int'(v_out), 32'sh7FFFFFFF);

    // R7 start while busy ignored
    load_all(32'sh0002_0000, 32'sh0000_4000, 32'sh0001_0000, 32'sh0003_0000,
             32'sh0001_0000, 32'shFFFF_0000, 1'b0);
    ev = m_next_v(); ef = m_next_f();
    do_step(5, -1, 0, 0, lat);
    chk("R7", "latency with extra start", lat, 12);
    chk("R7", "V", int'(v_out), ev);
    chk("R7", "F", int'(f_out), ef);
    m_v = ev; m_f = ef;
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R7", "no second done", extra, 0);
    chk("R7", "state kept", int'(v_out), ev);

    // R8 writes while busy ignored (inflow word, then V word)
    ev = m_next_v(); ef = m_next_f();
    do_step(-1, 3, 0, 32'sh0100_0000, lat);
    chk("R8", "V ignores busy write", int'(v_out), ev);
    chk("R8", "F ignores busy write", int'(f_out), ef);
    m_v = ev; m_f = ef;
    step_and_check("R8 stored inflow intact");
    ev = m_next_v(); ef = m_next_f();
    do_step(-1, 10, 4, 32'sh0ABC_0000, lat);
    chk("R8", "V word write ignored", int'(v_out), ev);
    m_v = ev; m_f = ef;
    step_and_check("R8 stored V intact");

    // constrained random
    for (int it = 0; it < 40; it++) begin
      int vals[6];
      for (int k = 0; k < 6; k++) begin
        if ($urandom % 5 == 0) vals[k] = int'($urandom);
        else vals[k] = int'($urandom % 32'h0080_0000) - 32'sh0040_0000;
      end
      load_all(vals[0], vals[1], vals[2], vals[3], vals[4], vals[5], 1'b1);
      step_and_check("R3 R4 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule